// File: doc/BRIEF.md
# Frame and Line Blanking Signal Generator

This block turns the line and frame state of a display timing generator into three timing outputs for the host: a frame-inactive flag, a per-line clock-disable signal and a composite blanking signal. It runs on a fast tick clock at four times the serial pixel-group rate. The input `sclk_en` marks the tick that ends each serial clock period, and every serial-rate register in the block moves only on that tick. The timing generator presents `line_active` and `frame_active` for the serial period that holds the first and the last shift-clock edges. The outputs are registered on the serial edge, so they change just ahead of the first pixel slot of a line or frame and just after the last one.

Clock-disable and frame-inactive are the registered inverses of the line and frame states. The block always forms clock-disable as it would for eight bits per pixel, so it takes no pixel-depth input. Blanking has the same shape as clock-disable but arrives later. The whole-cycle part of the lag comes from a four-bit control field and runs from one to nine serial cycles. A fixed quarter-cycle offset is added to it by updating blanking one tick after the serial edge. In interlaced operation, the first blanking fall after frame flyback in an even field is held back by a further half-line-derived count.

Top module: `blank_sync_gen`

## Requirements
- R1: On each serial edge (`sclk_en` high), `frame_inact` takes the inverse of `frame_active`.
- R2: On each serial edge, `clk_dis` takes the inverse of `line_active`. No pixel-depth setting exists, and the result is the eight-bit-per-pixel form.
- R3: `clk_dis` and `frame_inact` hold their values on every tick that is not a serial edge.
- R4: Outside the interlace hold, `blank` after serial edge s equals `clk_dis` after serial edge s−n, and is 1 when s−n precedes the first edge after reset. The lag is n = 2 − `blank_ctl[0]` + 4·`blank_ctl[3]` + 2·`blank_ctl[2]` + `blank_ctl[1]`.
- R5: `blank` changes only on the tick one after a serial edge, which is a quarter of a serial period after `clk_dis` moves.
- R6: With `interlace` and `even_field` high, the first fall of `blank` after a period with `frame_inact` high comes m serial cycles later than R4 gives. Here m = `line_time`/2 − (`backporch` + 2·`half_sync`), taken as 0 when that value is negative.
- R7: With `even_field` low, or on any later line of the field, `blank` follows R4 with no added lag.
- R8: While `rst` is high, `frame_inact`, `clk_dis` and `blank` are all 1 (inactive and blanked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, four ticks per serial period |
| rst | input | 1 | Synchronous reset, active high |
| sclk_en | input | 1 | High on the tick that ends each serial period |
| line_active | input | 1 | Line has pixel slots in this serial period |
| frame_active | input | 1 | Timing generator is in active display |
| blank_ctl | input | 4 | Blanking lag control field (see R4) |
| interlace | input | 1 | Interlaced scan selected |
| even_field | input | 1 | Current field is the even field |
| line_time | input | LT_W | Line length in serial cycles |
| backporch | input | LT_W | Back porch length in serial cycles |
| half_sync | input | LT_W | Half of the sync width in serial cycles |
| frame_inact | output | 1 | Frame-inactive flag |
| clk_dis | output | 1 | Per-line clock-disable |
| blank | output | 1 | Delayed composite blanking |

## Verification
Random line and frame patterns are run under every blanking control value, and `blank` is compared each serial period with the stored clock-disable history. A tap that is off by one, or a control bit with the wrong weight or sign, shows up as an edge one or more cycles out. `blank` is also sampled between the serial edge and the update tick. A design without the quarter-cycle offset would show the new value there a tick early. Directed interlace runs cover the even field with short and long base lags, a negative m that must be clamped, and the odd field. A design that held the wrong line, or held it for the wrong length, or wrapped a negative m into a huge count, would blank the first line too long or blank later lines as well.

// File: rtl/blank_sync_gen_pkg.sv
package blank_sync_gen_pkg;
   // Whole-cycle blanking lag encoded by the control field:
   // 2 - c[0] + 4*c[3] + 2*c[2] + c[1]
   function automatic int unsigned whole_lag(input logic [3:0] c);
      return 2 - int'(c[0]) + 4 * int'(c[3]) + 2 * int'(c[2]) + int'(c[1]);
   endfunction
endpackage

// File: rtl/blank_sync_state.sv
module blank_sync_state (
   input  logic clk,
   input  logic rst,
   input  logic sclk_en,
   input  logic line_active,
   input  logic frame_active,
   output logic frame_inact,
   output logic clk_dis
);
   // Both flags are registered on the serial edge; reset leaves them inactive.
   always_ff @(posedge clk) begin
      if (rst) begin
         frame_inact <= 1'b1;
         clk_dis     <= 1'b1;
      end else if (sclk_en) begin
         frame_inact <= ~frame_active;
         clk_dis     <= ~line_active;
      end
   end
endmodule

// File: rtl/blank_sync_delay.sv
module blank_sync_delay #(
   parameter int unsigned SR_LEN = 9,
   localparam int unsigned SEL_W = $clog2(SR_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sclk_en,
   input  logic             din,
   input  logic [SEL_W-1:0] sel,
   output logic             tap
);
   logic [SR_LEN-1:0] sr;

   // Stage j holds din as it was j+1 serial edges ago.
   always_ff @(posedge clk) begin
      if (rst)          sr <= '1;
      else if (sclk_en) sr <= {sr[SR_LEN-2:0], din};
   end

   assign tap = sr[sel];
endmodule

// File: rtl/blank_sync_hold.sv
module blank_sync_hold #(
   parameter int unsigned LT_W = 12
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            upd,
   input  logic            tap,
   input  logic            frame_inact,
   input  logic            interlace,
   input  logic            even_field,
   input  logic [LT_W-1:0] extra,
   output logic            blank
);
   logic            armed;
   logic            holding;
   logic [LT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         blank   <= 1'b1;
         armed   <= 1'b0;
         holding <= 1'b0;
         cnt     <= '0;
      end else if (upd) begin
         if (frame_inact && interlace && even_field) armed <= 1'b1;
         if (holding) begin
            if (tap) begin
               holding <= 1'b0;
               blank   <= 1'b1;
            end else if (cnt <= LT_W'(1)) begin
               holding <= 1'b0;
               blank   <= 1'b0;
            end else begin
               cnt <= cnt - LT_W'(1);
            end
         end else if (blank && !tap && armed && (extra != '0)) begin
            holding <= 1'b1;
            cnt     <= extra;
            armed   <= 1'b0;
         end else begin
            blank <= tap;
            if (blank && !tap) armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/blank_sync_gen.sv
module blank_sync_gen #(
   parameter int unsigned LT_W          = 12,
   parameter int unsigned DLY_TAPS      = 8,
   parameter bit          QUARTER_PHASE = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sclk_en,
   input  logic            line_active,
   input  logic            frame_active,
   input  logic [3:0]      blank_ctl,
   input  logic            interlace,
   input  logic            even_field,
   input  logic [LT_W-1:0] line_time,
   input  logic [LT_W-1:0] backporch,
   input  logic [LT_W-1:0] half_sync,
   output logic            frame_inact,
   output logic            clk_dis,
   output logic            blank
);
   localparam int unsigned SR_LEN = DLY_TAPS + 1;
   localparam int unsigned SEL_W  = $clog2(SR_LEN);
   localparam int unsigned SW     = LT_W + 2;

   if (DLY_TAPS < 8) begin : g_bad_taps
      $error("DLY_TAPS must cover a whole-cycle lag of nine");
   end
   if (LT_W < 2) begin : g_bad_width
      $error("LT_W too small");
   end

   logic             tap;
   logic             upd;
   logic [SEL_W-1:0] sel;
   logic [SW-1:0]    half_w;
   logic [SW-1:0]    sub_w;
   logic [LT_W-1:0]  extra;

   // Tap index is the lag minus one: stage 0 already lags by one serial cycle.
   assign sel = SEL_W'({1'b0, blank_ctl[3:1]}) + SEL_W'(1) - SEL_W'(blank_ctl[0]);

   // Interlace extra hold, clamped at zero when the difference goes negative.
   assign half_w = SW'(line_time >> 1);
   assign sub_w  = SW'(backporch) + (SW'(half_sync) << 1);
   assign extra  = (half_w > sub_w) ? LT_W'(half_w - sub_w) : '0;

   if (QUARTER_PHASE) begin : g_qtr
      logic sclk_en_d;
      always_ff @(posedge clk) begin
         if (rst) sclk_en_d <= 1'b0;
         else     sclk_en_d <= sclk_en;
      end
      assign upd = sclk_en_d;
   end else begin : g_edge
      assign upd = sclk_en;
   end

   blank_sync_state u_state (
      .clk         (clk),
      .rst         (rst),
      .sclk_en     (sclk_en),
      .line_active (line_active),
      .frame_active(frame_active),
      .frame_inact (frame_inact),
      .clk_dis     (clk_dis)
   );

   blank_sync_delay #(.SR_LEN(SR_LEN)) u_delay (
      .clk    (clk),
      .rst    (rst),
      .sclk_en(sclk_en),
      .din    (clk_dis),
      .sel    (sel),
      .tap    (tap)
   );

   blank_sync_hold #(.LT_W(LT_W)) u_hold (
      .clk        (clk),
      .rst        (rst),
      .upd        (upd),
      .tap        (tap),
      .frame_inact(frame_inact),
      .interlace  (interlace),
      .even_field (even_field),
      .extra      (extra),
      .blank      (blank)
   );
endmodule

// File: rtl/blank_sync_gen_chk.sv
module blank_sync_gen_chk (
   input logic clk,
   input logic rst,
   input logic sclk_en,
   input logic line_active,
   input logic frame_active,
   input logic frame_inact,
   input logic clk_dis,
   input logic blank
);
   // R1
   a_r1_frame_follow: assert property (@(posedge clk) disable iff (rst)
      sclk_en |=> (frame_inact == !$past(frame_active)));
   // R2
   a_r2_line_follow: assert property (@(posedge clk) disable iff (rst)
      sclk_en |=> (clk_dis == !$past(line_active)));
   // R3
   a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
      !sclk_en |=> ($stable(clk_dis) && $stable(frame_inact)));
   // R5
   a_r5_quarter_tick: assert property (@(posedge clk) disable iff (rst)
      !$stable(blank) |-> $past(sclk_en, 2));
   // R8
   a_r8_reset_state: assert property (@(posedge clk)
      rst |=> (frame_inact && clk_dis && blank));
endmodule

bind blank_sync_gen blank_sync_gen_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .sclk_en     (sclk_en),
   .line_active (line_active),
   .frame_active(frame_active),
   .frame_inact (frame_inact),
   .clk_dis     (clk_dis),
   .blank       (blank)
);

// File: tb/blank_sync_gen_bench.sv
module blank_sync_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LT_W = 12;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            sclk_en = 1'b0;
   logic            line_active = 1'b0;
   logic            frame_active = 1'b0;
   logic [3:0]      blank_ctl = '0;
   logic            interlace = 1'b0;
   logic            even_field = 1'b0;
   logic [LT_W-1:0] line_time = '0;
   logic [LT_W-1:0] backporch = '0;
   logic [LT_W-1:0] half_sync = '0;
   logic            frame_inact, clk_dis, blank;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int   s;
   int   n_lag;
   int   hold_lo, hold_hi;
   logic la_h [0:255];
   logic pre_blank, got_dis, got_fi, got_blank;

   always #(CLK_PERIOD/2) clk = ~clk;

   blank_sync_gen #(.LT_W(LT_W)) u_blank_sync_gen (
      .clk(clk), .rst(rst), .sclk_en(sclk_en), .line_active(line_active),
      .frame_active(frame_active), .blank_ctl(blank_ctl), .interlace(interlace),
      .even_field(even_field), .line_time(line_time), .backporch(backporch),
      .half_sync(half_sync), .frame_inact(frame_inact), .clk_dis(clk_dis),
      .blank(blank)
   );

   function automatic int lag_of(input logic [3:0] c);
      return 2 - int'(c[0]) + 4 * int'(c[3]) + 2 * int'(c[2]) + int'(c[1]);
   endfunction

   function automatic logic exp_blank(input int t);
      if (t >= hold_lo && t < hold_hi) return 1'b1;
      if (t < n_lag) return 1'b1;
      return ~la_h[t - n_lag];
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at serial %0d: actual=%0d expected=%0d", tag, s, act, exp);
      end
   endtask

   task automatic do_reset(input logic [3:0] c);
      @(negedge clk);
      rst = 1'b1; sclk_en = 1'b0; blank_ctl = c;
      repeat (3) @(negedge clk);
      check(frame_inact && clk_dis && blank, "R8 reset state", int'({frame_inact, clk_dis, blank}), 7);
      rst = 1'b0;
      s = 0; n_lag = lag_of(c); hold_lo = 0; hold_hi = 0;
   endtask

   task automatic step(input logic la, input logic fa);
      @(negedge clk);
      line_active = la; frame_active = fa; sclk_en = 1'b1; la_h[s] = la;
      @(negedge clk);
      sclk_en = 1'b0; pre_blank = blank;
      @(negedge clk);
      got_dis = clk_dis; got_fi = frame_inact; got_blank = blank;
      @(negedge clk);
   endtask

   task automatic step_check(input logic la, input logic fa, input string btag);
      logic eb, ep;
      step(la, fa);
      check(got_fi == ~fa, "R1 frame_inact", int'(got_fi), int'(~fa));
      check(got_dis == ~la, "R2 clk_dis", int'(got_dis), int'(~la));
      ep = (s == 0) ? 1'b1 : exp_blank(s - 1);
      check(pre_blank == ep, "R5 blank before update tick", int'(pre_blank), int'(ep));
      eb = exp_blank(s);
      check(got_blank == eb, btag, int'(got_blank), int'(eb));
      s++;
   endtask

   // R3: between serial edges the flags do not move
   task automatic idle_check;
      logic d0, f0;
      d0 = clk_dis; f0 = frame_inact;
      @(negedge clk); line_active = ~line_active; frame_active = ~frame_active;
      repeat (3) @(negedge clk);
      check(clk_dis == d0 && frame_inact == f0, "R3 no change without sclk_en",
            int'({clk_dis, frame_inact}), int'({d0, f0}));
   endtask

   task automatic interlace_run(input logic [3:0] c, input logic ev, input int lt,
                                input int bp, input int hs, input int extra_m);
      do_reset(c);
      interlace = 1'b1; even_field = ev;
      line_time = LT_W'(lt); backporch = LT_W'(bp); half_sync = LT_W'(hs);
      hold_lo = 5 + n_lag; hold_hi = 5 + n_lag + extra_m;
      for (int i = 0; i < 5; i++)  step_check(1'b0, 1'b0, "R6 flyback blank");
      for (int i = 0; i < 30; i++) step_check(1'b1, 1'b1, ev && extra_m > 0 ? "R6 first even line" : "R7 no extra lag");
      for (int i = 0; i < 10; i++) step_check(1'b0, 1'b1, "R7 line gap");
      for (int i = 0; i < 20; i++) step_check(1'b1, 1'b1, "R7 later line no hold");
      interlace = 1'b0; even_field = 1'b0;
   endtask

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      s = 0; n_lag = 2; hold_lo = 0; hold_hi = 0;
      repeat (2) @(negedge clk);

      // R4: every control value, random line/frame patterns
      for (int c = 0; c < 16; c++) begin
         logic la_cur, fa_cur;
         do_reset(4'(c));
         la_cur = 1'b0; fa_cur = 1'b1;
         for (int i = 0; i < 100; i++) begin
            if ($urandom % 6 == 0) la_cur = ~la_cur;
            if ($urandom % 20 == 0) fa_cur = ~fa_cur;
            step_check(la_cur, fa_cur, "R4 blank lag");
         end
         idle_check();
      end

      // R6: even field, base lag 2, m = 20 - 14 = 6
      interlace_run(4'b0000, 1'b1, 40, 6, 4, 6);
      // R6: even field, base lag 8, m = 6
      interlace_run(4'b1111, 1'b1, 40, 6, 4, 6);
      // R6: negative difference clamps to zero
      interlace_run(4'b0010, 1'b1, 20, 6, 4, 0);
      // R7: odd field gets no extra lag
      interlace_run(4'b0000, 1'b0, 40, 6, 4, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired: actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule